// File: doc/BRIEF.md
# Transfer Descriptor Slot Scheduler

The scheduler owns a buffer of 32 transfer-descriptor slots and, once per frame, walks them in ascending index order starting at slot 0. Host software steers the walk with two bitmaps it can write and read back: a pass-over map, where a 1 tells the scheduler to step past that slot, and an end-of-list map, where a 1 marks the final slot of the periodic list. Each slot that is not passed over is given to a descriptor-execution engine through a start pulse carrying the slot index. The engine answers with a completion pulse and a success flag.

Successful completions are recorded in a completion bitmap. Software clears it by pulsing ones on a separate clear input. The index of the slot in progress can be read back, so software knows which locations it may refill. When the list ends, the scheduler raises a one-cycle handoff pulse so that the controller moves on to the asynchronous transfer list. The list ends when the marked slot finishes or is passed over, or after slot 31 if no slot is marked.

Top module: `slot_sched`

## Requirements
- R1: After a synchronous reset, the pass-over map, end-of-list map, completion map and active index all read 0, and neither `eng_start` nor `handoff` is asserted.
- R2: A `frame_start` pulse taken while idle starts a walk at slot 0. Slots are visited in strictly ascending order, and every slot that is not passed over gets one single-cycle `eng_start` with `eng_slot` equal to its index.
- R3: A slot whose pass-over bit is 1 when the walk reaches it is not started. Once software clears that bit, the slot is started again on the next walk.
- R4: When the slot whose end-of-list bit is 1 completes, or is passed over, `handoff` pulses for exactly one cycle. No further slot is started until the next `frame_start`.
- R5: With no end-of-list bit set, the walk ends after slot 31 with a `handoff` pulse. This also holds when every slot is passed over and nothing is started.
- R6: A completion-map bit becomes 1 only when the engine completes that slot with `eng_ok`=1. A completion with `eng_ok`=0 leaves the bit at 0.
- R7: Each 1 on `done_clr` clears the matching completion bit. If a clear and a successful completion hit the same bit in the same cycle, the bit ends up 1.
- R8: The active index equals the slot in progress and holds steady for as long as the engine is busy with it. The active register is read-only: a write at code 0x9A has no effect.
- R9: A pass-over write to the slot in progress does not abort it. Its completion is still recorded, and the new bit applies from the next walk.
- R10: Register codes: a read at 0x18 returns the pass-over map, 0x19 the end-of-list map, 0x17 the completion map, and 0x1A the active index in bits 4:0. Writes go to 0x98 for the pass-over map and 0x99 for the end-of-list map. Bit n of each map is slot n. Read data appears on `reg_rdata` in the cycle after `reg_rd`, and any other read code returns 0.
- R11: A `frame_start` that arrives while a walk is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Begins a walk from slot 0 when idle |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register code |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| done_clr | input | 32 | Write-one-to-clear strobe for the completion map |
| eng_start | output | 1 | One-cycle request to run slot `eng_slot` |
| eng_slot | output | 5 | Slot in progress (also the active index) |
| eng_done | input | 1 | Engine completion pulse |
| eng_ok | input | 1 | Completion succeeded, valid with `eng_done` |
| handoff | output | 1 | One-cycle pulse: periodic list finished |

## Verification
The engine's success completion and a software clear of the completion map can land on the same clock edge. The bench provokes this by having its engine model drive an all-ones clear in the same cycle as every completion pulse of a frame. Only the set from the final completion may survive, so the map must then read back with just that slot's bit. A second coincidence arises when software rewrites the pass-over map while the engine is busy with that very slot. The scoreboard judges this case by checking that the completion still arrives and that the slot disappears from the next walk.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_BUSY} sched_st_t;

  localparam logic [7:0] ADR_DONE_RD = 8'h17;
  localparam logic [7:0] ADR_SKIP_RD = 8'h18;
  localparam logic [7:0] ADR_LAST_RD = 8'h19;
  localparam logic [7:0] ADR_ACT_RD  = 8'h1A;
  localparam logic [7:0] ADR_SKIP_WR = 8'h98;
  localparam logic [7:0] ADR_LAST_WR = 8'h99;
endpackage

// File: rtl/sched_regs.sv
module sched_regs
  import slot_sched_pkg::*;
#(
  parameter int NSLOT = 32,
  parameter int IDXW  = $clog2(NSLOT),
  parameter int AW    = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [NSLOT-1:0] done_clr,
  input  logic             set_en,
  input  logic [IDXW-1:0]  set_idx,
  input  logic [IDXW-1:0]  act_idx,
  output logic [NSLOT-1:0] skip_map,
  output logic [NSLOT-1:0] last_map,
  output logic [NSLOT-1:0] done_map
);
  logic [DW-1:0] rd_mux;

  // host-written maps
  always_ff @(posedge clk) begin
    if (rst) begin
      skip_map <= '0;
      last_map <= '0;
    end else if (reg_wr) begin
      if (reg_addr == AW'(ADR_SKIP_WR)) skip_map <= reg_wdata[NSLOT-1:0];
      if (reg_addr == AW'(ADR_LAST_WR)) last_map <= reg_wdata[NSLOT-1:0];
    end
  end

  // completion bits: a set from the engine beats a clear in the same cycle
  for (genvar i = 0; i < NSLOT; i++) begin : g_done
    always_ff @(posedge clk) begin
      if (rst)                                   done_map[i] <= 1'b0;
      else if (set_en && set_idx == IDXW'(i))    done_map[i] <= 1'b1;
      else if (done_clr[i])                      done_map[i] <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if      (reg_addr == AW'(ADR_SKIP_RD)) rd_mux[NSLOT-1:0] = skip_map;
    else if (reg_addr == AW'(ADR_LAST_RD)) rd_mux[NSLOT-1:0] = last_map;
    else if (reg_addr == AW'(ADR_DONE_RD)) rd_mux[NSLOT-1:0] = done_map;
    else if (reg_addr == AW'(ADR_ACT_RD))  rd_mux[IDXW-1:0]  = act_idx;
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/sched_scan.sv
module sched_scan
  import slot_sched_pkg::*;
#(
  parameter int NSLOT = 32,
  parameter int IDXW  = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic [NSLOT-1:0] skip_map,
  input  logic [NSLOT-1:0] last_map,
  input  logic             eng_done,
  input  logic             eng_ok,
  output logic             eng_start,
  output logic [IDXW-1:0]  cur,
  output logic             handoff,
  output logic             set_en,
  output logic [IDXW-1:0]  set_idx
);
  localparam logic [IDXW-1:0] TOP_IDX = IDXW'(NSLOT - 1);

  sched_st_t st;
  logic      at_end;

  assign at_end  = last_map[cur] || (cur == TOP_IDX);
  assign set_en  = (st == ST_BUSY) && eng_done && eng_ok;
  assign set_idx = cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cur       <= '0;
      eng_start <= 1'b0;
      handoff   <= 1'b0;
    end else begin
      eng_start <= 1'b0;
      handoff   <= 1'b0;
      unique case (st)
        ST_IDLE: if (frame_start) begin
          cur <= '0;
          st  <= ST_SCAN;
        end
        ST_SCAN: if (skip_map[cur]) begin
          if (at_end) begin
            handoff <= 1'b1;
            st      <= ST_IDLE;
          end else begin
            cur <= cur + 1'b1;
          end
        end else begin
          eng_start <= 1'b1;
          st        <= ST_BUSY;
        end
        ST_BUSY: if (eng_done) begin
          if (at_end) begin
            handoff <= 1'b1;
            st      <= ST_IDLE;
          end else begin
            cur <= cur + 1'b1;
            st  <= ST_SCAN;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slot_sched.sv
module slot_sched
  import slot_sched_pkg::*;
#(
  parameter int NSLOT = 32,
  parameter int AW    = 8,
  parameter int DW    = 32,
  localparam int IDXW = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [NSLOT-1:0] done_clr,
  output logic             eng_start,
  output logic [IDXW-1:0]  eng_slot,
  input  logic             eng_done,
  input  logic             eng_ok,
  output logic             handoff
);
  logic [NSLOT-1:0] skip_map, last_map, done_map;
  logic             set_en;
  logic [IDXW-1:0]  set_idx;

  sched_regs #(.NSLOT(NSLOT), .IDXW(IDXW), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .done_clr(done_clr), .set_en(set_en), .set_idx(set_idx),
    .act_idx(eng_slot), .skip_map(skip_map), .last_map(last_map),
    .done_map(done_map)
  );

  sched_scan #(.NSLOT(NSLOT), .IDXW(IDXW)) u_scan (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .skip_map(skip_map), .last_map(last_map),
    .eng_done(eng_done), .eng_ok(eng_ok), .eng_start(eng_start),
    .cur(eng_slot), .handoff(handoff), .set_en(set_en), .set_idx(set_idx)
  );
endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
  parameter int NSLOT = 32,
  parameter int IDXW  = $clog2(NSLOT)
) (
  input logic             clk,
  input logic             rst,
  input logic             eng_start,
  input logic [IDXW-1:0]  eng_slot,
  input logic             eng_done,
  input logic             eng_ok,
  input logic             handoff,
  input logic [NSLOT-1:0] done_map
);
  logic chk_busy;

  always_ff @(posedge clk) begin
    if (rst)            chk_busy <= 1'b0;
    else if (eng_start) chk_busy <= 1'b1;
    else if (eng_done)  chk_busy <= 1'b0;
  end

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);

  assert_handoff_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    handoff |=> !handoff);

  assert_no_start_at_handoff_R4: assert property (@(posedge clk) disable iff (rst)
    !(handoff && eng_start));

  assert_no_restart_busy_R11: assert property (@(posedge clk) disable iff (rst)
    chk_busy |-> !eng_start);

  assert_active_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (chk_busy && !eng_done) |=> $stable(eng_slot));

  // also covers R7: the set survives a same-cycle clear
  assert_done_set_R6: assert property (@(posedge clk) disable iff (rst)
    (chk_busy && eng_done && eng_ok) |=> done_map[$past(eng_slot)]);
endmodule

bind slot_sched sched_chk #(.NSLOT(NSLOT), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst(rst), .eng_start(eng_start), .eng_slot(eng_slot),
  .eng_done(eng_done), .eng_ok(eng_ok), .handoff(handoff), .done_map(done_map)
);

// File: tb/sim_slot_sched.sv
module sim_slot_sched;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fs_drv = 1'b0, fs_eng = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic [31:0] clr_drv = '0, clr_eng = '0;
  logic        eng_start, eng_done = 1'b0, eng_ok = 1'b0, handoff;
  logic [4:0]  eng_slot;

  int          n_chk = 0, n_err = 0;
  int          exp_q[$];
  logic [31:0] ok_map = '1;
  int          eng_lat = 2;
  bit          clr_race = 1'b0, fs_poke = 1'b0;

  always #2 clk = ~clk;

  slot_sched u0 (
    .clk(clk), .rst(rst), .frame_start(fs_drv | fs_eng),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done_clr(clr_drv | clr_eng),
    .eng_start(eng_start), .eng_slot(eng_slot), .eng_done(eng_done),
    .eng_ok(eng_ok), .handoff(handoff)
  );

  task automatic chk(bit good, string req, longint act, longint exp);
    n_chk++;
    if (!good) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic clear_done();
    @(negedge clk); clr_drv = '1;
    @(negedge clk); clr_drv = '0;
  endtask

  task automatic pulse_frame();
    @(negedge clk); fs_drv = 1'b1;
    @(negedge clk); fs_drv = 1'b0;
  endtask

  task automatic wait_handoff(string req);
    int t = 0;
    while (!handoff && t < 3000) begin @(negedge clk); t++; end
    chk(handoff, req, handoff, 1);
    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // driver: compute the expected walk and queue it
  task automatic run_frame(logic [31:0] sk, logic [31:0] ls, string req,
                           output logic [31:0] exp_done);
    exp_done = '0;
    wr(8'h98, sk);
    wr(8'h99, ls);
    clear_done();
    for (int i = 0; i < 32; i++) begin
      if (!sk[i]) begin
        exp_q.push_back(i);
        if (ok_map[i]) exp_done[i] = 1'b1;
      end
      if (ls[i]) break;
    end
    pulse_frame();
    wait_handoff(req);
  endtask

  // engine model
  initial begin
    forever begin
      @(negedge clk);
      if (eng_start) begin
        automatic int s = eng_slot;
        repeat (eng_lat) begin
          @(negedge clk);
          if (fs_poke) fs_eng = 1'b1; else fs_eng = 1'b0;
        end
        fs_eng = 1'b0;
        eng_done = 1'b1; eng_ok = ok_map[s];
        if (clr_race) clr_eng = '1;
        @(negedge clk);
        eng_done = 1'b0; eng_ok = 1'b0; clr_eng = '0;
      end
    end
  end

  // monitor: pop expected slot on each start
  always @(negedge clk) begin
    if (!rst && eng_start) begin
      if (exp_q.size() == 0) chk(1'b0, "R2 unexpected start", eng_slot, 0);
      else begin
        automatic int e = exp_q.pop_front();
        chk(eng_slot == e[4:0], "R2 start order", eng_slot, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d, ed;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(!eng_start && !handoff, "R1 outputs", {eng_start, handoff}, 0);
    rd(8'h18, d); chk(d == 0, "R1 skip", d, 0);
    rd(8'h19, d); chk(d == 0, "R1 last", d, 0);
    rd(8'h17, d); chk(d == 0, "R1 done", d, 0);
    rd(8'h1A, d); chk(d == 0, "R1 active", d, 0);
    // R10 register codes
    wr(8'h98, 32'hA5A5_0F0F); rd(8'h18, d); chk(d == 32'hA5A5_0F0F, "R10 skip", d, 32'hA5A5_0F0F);
    wr(8'h99, 32'h0000_8001); rd(8'h19, d); chk(d == 32'h0000_8001, "R10 last", d, 32'h8001);
    rd(8'h55, d); chk(d == 0, "R10 unknown code", d, 0);
    wr(8'h9A, 32'h1F); rd(8'h1A, d); chk(d == 0, "R8 active read-only", d, 0);
    // R2 R6 R4: straight run to a marked slot
    run_frame(32'h0, 32'h20, "R4 last slot", ed);
    rd(8'h17, d); chk(d == ed, "R6 done map", d, ed);
    // R7 plain clear
    @(negedge clk); clr_drv = 32'h5; @(negedge clk); clr_drv = '0;
    rd(8'h17, d); chk(d == 32'h3A, "R7 clear", d, 32'h3A);
    // R3 R6: passes over and a failed completion
    ok_map = ~32'h8;
    run_frame(32'h16, 32'h40, "R3 skip walk", ed);
    rd(8'h17, d); chk(d == ed, "R6 fail not recorded", d, ed);
    ok_map = '1;
    // R3 re-eligible after clearing bit 2
    run_frame(32'h12, 32'h4, "R3 re-eligible", ed);
    // R4 passed-over last slot
    run_frame(32'h8, 32'h8, "R4 skipped last", ed);
    // R5 no last bit
    run_frame(~32'h8000_0001, 32'h0, "R5 end at 31", ed);
    run_frame(32'hFFFF_FFFF, 32'h0, "R5 all skipped", ed);
    // R7 race: every completion coincides with a full clear
    clr_race = 1'b1;
    run_frame(32'h0, 32'h8, "R7 race", ed);
    rd(8'h17, d); chk(d == 32'h8, "R7 set wins", d, 32'h8);
    clr_race = 1'b0;
    // R8 R9 R11: long engine latency, poke frame_start while busy
    eng_lat = 12; fs_poke = 1'b1;
    wr(8'h98, 32'h0); wr(8'h99, 32'h4); clear_done();
    exp_q.push_back(0); exp_q.push_back(1); exp_q.push_back(2);
    pulse_frame();
    while (!(eng_start && eng_slot == 5'd1)) @(negedge clk);
    rd(8'h1A, d); chk(d == 1, "R8 active", d, 1);
    wr(8'h9A, 32'h7);
    rd(8'h1A, d); chk(d == 1, "R8 holds", d, 1);
    wr(8'h98, 32'h2);
    wait_handoff("R11 poke ignored");
    rd(8'h17, d); chk(d == 32'h7, "R9 completion kept", d, 32'h7);
    fs_poke = 1'b0; eng_lat = 2;
    run_frame(32'h2, 32'h4, "R9 next walk", ed);
    rd(8'h17, d); chk(d == 32'h5, "R9 slot passed over", d, 32'h5);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule